// File: doc/BRIEF.md
# Timer Tick Prescaler with Odd-Coded Divider

This block turns a free-running base oscillator (nominally 18 MHz) into tick-enable strobes for two timers. It does not make a new clock. A single shared phase counter divides the base clock by a ratio taken from a 6-bit divider code. Each timer has its own gate input that passes or blocks that shared strobe. A timer that sits idle, or that counts from an external clock, has its gate turned off and sees no internal ticks.

The divider code uses an unusual encoding. Any code with bit 0 set means no division. Code zero divides by two. Each remaining even code N (2 to 62) divides by N. The ratio in use is latched only when the phase counter wraps, so a change to the code never shortens or stretches the interval already in progress.

Top module: `tmr_tick_prescaler`

## Requirements
- R1: When the divider code is odd (bit 0 = 1), a gated-on tick output is high in every base cycle.
- R2: When the divider code is an even value N with 2 <= N <= 62, a gated-on tick output is a one-cycle pulse every N base cycles.
- R3: When the divider code is 0, a gated-on tick output is a one-cycle pulse every 2 base cycles.
- R4: While a timer's gate input is low, that timer's tick output is low in the following cycle and stays low. The other timer's ticks are unaffected.
- R5: Both timers share one phase, so two gated-on tick outputs are always equal.
- R6: A divider code change is applied at the next wrap of the phase counter. The interval in progress completes at the old ratio, and the interval after it uses the new ratio.
- R7: While reset is asserted, all tick outputs are low. After release, a gated-on tick rises after the first clock edge. From then on it follows the ratio of the code sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_code_i | input | CODE_W (6) | Divider code: odd = /1, 0 = /2, even N = /N |
| gate_en_i | input | NUM_TIMERS (2) | Per-timer internal tick gate, 1 = pass ticks |
| tick_o | output | NUM_TIMERS (2) | Per-timer tick-enable strobe |

## Verification
The hardest case to reach from the ports is a code change in the middle of a long interval. The change must be shown not to cut that interval short, which means the stimulus has to land at a known phase. The bench first aligns to a tick at ratio 10 and waits three cycles before switching to ratio 4. It then expects the current interval to finish at 10 cycles and the next one to take 4. A sweep over all 64 codes, each applied right after a tick, covers the odd, zero and even encodings.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;

  typedef enum logic [1:0] {
    DIV_BYPASS = 2'd0,
    DIV_HALF   = 2'd1,
    DIV_EVEN   = 2'd2
  } div_kind_e;

  // Encoding: low bit set -> no division; all-zero -> divide by two.
  function automatic div_kind_e classify(input logic lsb, input logic is_zero);
    if (lsb)          return DIV_BYPASS;
    else if (is_zero) return DIV_HALF;
    else              return DIV_EVEN;
  endfunction

endpackage

// File: rtl/tick_ratio_decode.sv
module tick_ratio_decode #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] last_o
);
  import tick_div_pkg::*;

  div_kind_e kind;

  always_comb begin
    kind = classify(code_i[0], code_i == '0);
    unique case (kind)
      DIV_BYPASS: last_o = '0;
      DIV_HALF:   last_o = CODE_W'(1);
      default:    last_o = code_i - CODE_W'(1);
    endcase
  end
endmodule

// File: rtl/tick_phase_counter.sv
module tick_phase_counter #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] next_last_i,
  output logic              term_o,
  output logic [CODE_W-1:0] cnt_o,
  output logic [CODE_W-1:0] last_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] last_q;

  assign term_o = (cnt_q == last_q);
  assign cnt_o  = cnt_q;
  assign last_o = last_q;

  // Ratio is reloaded only at wrap, so intervals are never cut short.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (term_o) begin
      cnt_q  <= '0;
      last_q <= next_last_i;
    end else begin
      cnt_q  <= cnt_q + CODE_W'(1);
    end
  end
endmodule

// File: rtl/tick_gate_stage.sv
module tick_gate_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic term_i,
  input  logic gate_i,
  output logic tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= term_i & gate_i;
  end
endmodule

// File: rtl/tmr_tick_prescaler.sv
module tmr_tick_prescaler #(
  parameter int CODE_W     = 6,
  parameter int NUM_TIMERS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CODE_W-1:0]     div_code_i,
  input  logic [NUM_TIMERS-1:0] gate_en_i,
  output logic [NUM_TIMERS-1:0] tick_o
);
  logic [CODE_W-1:0] next_last;
  logic [CODE_W-1:0] phase_cnt;
  logic [CODE_W-1:0] phase_last;
  logic              phase_term;

  tick_ratio_decode #(.CODE_W(CODE_W)) u_decode (
    .code_i (div_code_i),
    .last_o (next_last)
  );

  tick_phase_counter #(.CODE_W(CODE_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .next_last_i (next_last),
    .term_o      (phase_term),
    .cnt_o       (phase_cnt),
    .last_o      (phase_last)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_gate
    tick_gate_stage u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .term_i (phase_term),
      .gate_i (gate_en_i[t]),
      .tick_o (tick_o[t])
    );
  end
endmodule

// File: rtl/tmr_tick_prescaler_chk.sv
module tmr_tick_prescaler_chk #(
  parameter int CODE_W     = 6,
  parameter int NUM_TIMERS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CODE_W-1:0]     div_code_i,
  input logic [NUM_TIMERS-1:0] gate_en_i,
  input logic [NUM_TIMERS-1:0] tick_o,
  input logic                  phase_term,
  input logic [CODE_W-1:0]     phase_cnt,
  input logic [CODE_W-1:0]     phase_last
);
  a_r1_odd_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_term && div_code_i[0]) |=> phase_term);

  a_r2_even_ratio_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_term && !div_code_i[0] && div_code_i != '0)
      |=> (phase_last == $past(div_code_i) - CODE_W'(1)));

  a_r2_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_cnt <= phase_last);

  a_r3_zero_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_term && div_code_i == '0) |=> !phase_term ##1 phase_term);

  a_r6_ratio_held_mid_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_term |=> $stable(phase_last));

  a_r5_shared_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&gate_en_i) |=> (tick_o == {NUM_TIMERS{tick_o[0]}}));

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    a_r4_gate_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_en_i[g] |=> !tick_o[g]);
  end
endmodule

bind tmr_tick_prescaler tmr_tick_prescaler_chk #(
  .CODE_W(CODE_W), .NUM_TIMERS(NUM_TIMERS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_code_i (div_code_i),
  .gate_en_i  (gate_en_i),
  .tick_o     (tick_o),
  .phase_term (phase_term),
  .phase_cnt  (phase_cnt),
  .phase_last (phase_last)
);

// File: tb/tmr_tick_prescaler_bench.sv
module tmr_tick_prescaler_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] div_code_i = 6'd8;
  logic [1:0] gate_en_i = 2'b11;
  logic [1:0] tick_o;

  int n_run = 0;
  int n_fail = 0;
  int mism = 0;
  bit watch_mism = 0;

  always #5 clk_i = ~clk_i;

  tmr_tick_prescaler u_tmr_tick_prescaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_code_i(div_code_i),
    .gate_en_i(gate_en_i), .tick_o(tick_o)
  );

  function automatic int exp_ratio(input int c);
    if (c % 2 == 1) return 1;
    if (c == 0)     return 2;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycles (negedges) until the chosen tick is seen high.
  task automatic wait_tick(input int idx, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_o[idx] && n < 300);
  endtask

  always @(negedge clk_i)
    if (watch_mism && tick_o[0] != tick_o[1]) mism++;

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, n1, n2, cnt0, cnt1;
    // R7: reset state and first tick
    repeat (3) @(negedge clk_i);
    check(tick_o == 2'b00, "R7 reset ticks low", tick_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(tick_o == 2'b11, "R7 first tick after release", tick_o, 3);
    wait_tick(0, n);
    check(n == 8, "R7 ratio from code at release", n, 8);

    // R1 R2 R3 R5: full sweep of the code space
    watch_mism = 1;
    for (int c = 0; c < 64; c++) begin
      div_code_i = 6'(c);
      wait_tick(0, n);
      wait_tick(0, n1);
      wait_tick(0, n2);
      if (c % 2 == 1)
        check(n1 == 1 && n2 == 1, "R1 odd code", n1 * 100 + n2, 101);
      else if (c == 0)
        check(n1 == 2 && n2 == 2, "R3 zero code", n1 * 100 + n2, 202);
      else
        check(n1 == c && n2 == c, "R2 even code", n1 * 100 + n2, exp_ratio(c) * 101);
    end
    watch_mism = 0;
    check(mism == 0, "R5 shared phase", mism, 0);

    // R4: gate off blocks one timer only
    div_code_i = 6'd4;
    wait_tick(0, n);
    wait_tick(0, n);
    gate_en_i = 2'b01;
    @(negedge clk_i);
    cnt0 = 0; cnt1 = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      if (tick_o[0]) cnt0++;
      if (tick_o[1]) cnt1++;
    end
    check(cnt1 == 0, "R4 gated timer silent", cnt1, 0);
    check(cnt0 == 15, "R4 other timer unaffected", cnt0, 15);
    gate_en_i = 2'b11;
    wait_tick(0, n);
    wait_tick(0, n);
    check(tick_o[1] == 1'b1, "R4 re-enabled timer in phase", tick_o[1], 1);

    // R6: mid-interval code change
    div_code_i = 6'd10;
    wait_tick(0, n);
    wait_tick(0, n);
    repeat (3) @(negedge clk_i);
    div_code_i = 6'd4;
    wait_tick(0, n);
    check(n + 3 == 10, "R6 current interval keeps old ratio", n + 3, 10);
    wait_tick(0, n);
    check(n == 4, "R6 next interval uses new ratio", n, 4);

    // R3 again after a long ratio, code zero applied mid-interval
    div_code_i = 6'd62;
    wait_tick(0, n);
    wait_tick(0, n);
    check(n == 62, "R2 largest even code", n, 62);
    repeat (5) @(negedge clk_i);
    div_code_i = 6'd0;
    wait_tick(0, n);
    check(n + 5 == 62, "R6 change into zero code", n + 5, 62);
    wait_tick(0, n);
    check(n == 2, "R3 zero code after change", n, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule